// File: doc/BRIEF.md
# Range-Stepping ADC Resolution Extender

This controller gets a 10-bit reading out of an external 8-bit ADC. An external analog summing stage subtracts one of a set of fixed offsets from the amplified input, and the block drives the select lines for those offsets. When a request arrives, the block clears every select and starts a conversion. If the sample comes back at full scale, the input lies above the current quarter. The block then moves the selects to the next quarter and converts again.

There are at most four tries. The first unsaturated sample ends the search. The fourth try is taken as it comes. The result places the quarter index above the final 8-bit sample, and a busy flag covers the whole search. The ADC is reached through a start pulse and a done pulse, with the data valid while done is high.

Top module: `rse_top`

## Requirements
- R1: After synchronous active-high reset, busy, result_valid, adc_start and all offset selects are 0, and result is 0.
- R2: A start request while idle sets busy in the next cycle with all selects at 0. One cycle later adc_start goes high for exactly one cycle.
- R3: A sample other than 0xFF ends the search. result becomes {try index (2 bits), sample (8 bits)}, where the first try has index 0.
- R4: A sample of 0xFF on tries 0 to 2 starts the next try. The select codes seen at each ADC start are, as ofs_sel[2:0], 000, 001, 010 and 100 for tries 0 to 3.
- R5: The sample of try 3 is accepted whatever its value, 0xFF included, and is reported with index 3.
- R6: After try 3 completes, every select is back at 0.
- R7: When the search ends on try 0, 1 or 2, the selects keep that try's code until the next start request.
- R8: result_valid is a one-cycle pulse. It is raised in the same cycle that busy falls and result takes its new value, and result stays unchanged between pulses.
- R9: A start request while busy is ignored. It causes no extra ADC start, and no new search begins after the current one ends.
- R10: Each try issues exactly one ADC start, so a search that ends on index k makes k+1 ADC starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request a high-resolution conversion |
| adc_start | output | 1 | One-cycle conversion start to the ADC |
| adc_done | input | 1 | One-cycle completion from the ADC |
| adc_data | input | 8 | ADC sample, valid with adc_done |
| ofs_sel | output | 3 | Offset selects; bit k adds offset weight k+1 |
| busy | output | 1 | Search in progress |
| result_valid | output | 1 | One-cycle pulse when result updates |
| result | output | 10 | {range index, final sample} |

## Verification
Most searches are random, with the number of saturated tries (0 to 3) and the ADC latency drawn freely. These show whether the index, the sample and the number of ADC starts all match the point where the saturation stopped. Directed runs use a sample of 0xFE at index 0 and 0x00 to probe the edges of the saturation test, and 0xFF on the last try to show that this try is taken without a check. The select code recorded at each ADC start separates a wrong step order from a wrong final index. Requests raised in the middle of a search show whether the block ignores them while busy.

// File: rtl/rse_pkg.sv
package rse_pkg;
    localparam int SAMPLE_W  = 8;
    localparam int NUM_TRIES = 4;
    localparam int RANGE_W   = $clog2(NUM_TRIES);
    localparam int SEL_W     = NUM_TRIES - 1;
    localparam int RESULT_W  = RANGE_W + SAMPLE_W;
    localparam logic [RANGE_W-1:0] LAST_IDX = RANGE_W'(NUM_TRIES - 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [RANGE_W-1:0]  range_idx;
        logic [SAMPLE_W-1:0] sample;
    } hires_word_t;

    // Select code for a given try: try 0 selects nothing, try i selects bit i-1.
    function automatic logic [SEL_W-1:0] try_code(input logic [RANGE_W-1:0] idx);
        logic [SEL_W-1:0] code;
        code = '0;
        for (int i = 1; i < NUM_TRIES; i++) begin
            if (int'(idx) == i) code[i-1] = 1'b1;
        end
        return code;
    endfunction

    function automatic logic is_full_scale(input logic [SAMPLE_W-1:0] s);
        return &s;
    endfunction
endpackage

// File: rtl/rse_judge.sv
module rse_judge
    import rse_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [RANGE_W-1:0]  try_idx,
    output logic                saturated,
    output logic                final_try
);
    always_comb begin
        saturated = is_full_scale(sample);
        final_try = (try_idx == LAST_IDX);
    end
endmodule

// File: rtl/rse_seq.sv
module rse_seq
    import rse_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic               adc_done,
    input  logic               saturated,
    input  logic               final_try,
    output logic [RANGE_W-1:0] try_idx,
    output logic [SEL_W-1:0]   ofs_sel,
    output logic               adc_start,
    output logic               busy,
    output logic               accept
);
    seq_state_t state;
    logic       step_up;

    always_comb begin
        accept  = (state == ST_WAIT) && adc_done && (!saturated || final_try);
        step_up = (state == ST_WAIT) && adc_done && saturated && !final_try;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            try_idx   <= '0;
            ofs_sel   <= '0;
            adc_start <= 1'b0;
            busy      <= 1'b0;
        end else begin
            adc_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        try_idx <= '0;
                        ofs_sel <= '0;
                        busy    <= 1'b1;
                        state   <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    adc_start <= 1'b1;
                    state     <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (step_up) begin
                        try_idx <= try_idx + 1'b1;
                        ofs_sel <= try_code(try_idx + 1'b1);
                        state   <= ST_LAUNCH;
                    end else if (accept) begin
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                        if (final_try) ofs_sel <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: never more than one offset select active
    p_sel_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ofs_sel));
    // R2: start is a single-cycle pulse
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    // R2: a new search begins with every select cleared
    p_rise_clear_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (ofs_sel == '0));
    // R10: no ADC start outside a search
    p_start_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> busy);
    // R9: a request during a search does not end it early
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req && !adc_done) |=> busy);
endmodule

// File: rtl/rse_result.sv
module rse_result
    import rse_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [RANGE_W-1:0]  try_idx,
    input  logic [SAMPLE_W-1:0] sample,
    output hires_word_t         word,
    output logic                valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= accept;
            if (accept) begin
                word.range_idx <= try_idx;
                word.sample    <= sample;
            end
        end
    end

    // R8: result only moves together with the valid pulse
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(word));
    // R3: below the top range the reported sample is never full scale
    p_low_unsat_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && word.range_idx != LAST_IDX) |-> !is_full_scale(word.sample));
endmodule

// File: rtl/rse_top.sv
module rse_top
    import rse_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    output logic                adc_start,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic [SEL_W-1:0]    ofs_sel,
    output logic                busy,
    output logic                result_valid,
    output logic [RESULT_W-1:0] result
);
    logic [RANGE_W-1:0] try_idx;
    logic               saturated;
    logic               final_try;
    logic               accept;
    hires_word_t        word;

    rse_judge u_judge (
        .sample    (adc_data),
        .try_idx   (try_idx),
        .saturated (saturated),
        .final_try (final_try)
    );

    rse_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .adc_done  (adc_done),
        .saturated (saturated),
        .final_try (final_try),
        .try_idx   (try_idx),
        .ofs_sel   (ofs_sel),
        .adc_start (adc_start),
        .busy      (busy),
        .accept    (accept)
    );

    rse_result u_result (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .try_idx (try_idx),
        .sample  (adc_data),
        .word    (word),
        .valid   (result_valid)
    );

    assign result = word;

    // R8: valid pulse coincides with busy dropping
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> !busy);
    // R6: the last try leaves all selects cleared
    p_top_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (result_valid && result[RESULT_W-1 -: RANGE_W] == LAST_IDX) |-> (ofs_sel == '0));
    // R8: valid never lasts two cycles
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);
endmodule

// File: tb/tb_rse_top.sv
module tb_rse_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       adc_start;
    logic       adc_done = 1'b0;
    logic [7:0] adc_data = 8'h00;
    logic [2:0] ofs_sel;
    logic       busy;
    logic       result_valid;
    logic [9:0] result;

    int errors = 0;
    int checks = 0;

    logic [7:0] plan [4];
    logic [2:0] sel_seen [4];
    int try_n = 0;
    int starts = 0;
    int cnt = 0;
    int lat = 2;

    always #4 clk = ~clk;

    rse_top dut (
        .clk(clk), .rst(rst), .start_req(start_req), .adc_start(adc_start),
        .adc_done(adc_done), .adc_data(adc_data), .ofs_sel(ofs_sel),
        .busy(busy), .result_valid(result_valid), .result(result)
    );

    // ADC model, driven on the falling edge
    always @(negedge clk) begin
        adc_done = 1'b0;
        if (adc_start) begin
            if (try_n < 4) sel_seen[try_n] = ofs_sel;
            starts = starts + 1;
            cnt = lat;
        end else if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                adc_done = 1'b1;
                adc_data = (try_n < 4) ? plan[try_n] : 8'h00;
                try_n = try_n + 1;
            end
        end
    end

    function automatic logic [2:0] exp_code(input int i);
        return (i == 0) ? 3'b000 : 3'(1 << (i - 1));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int k, input logic [7:0] fin, input bit inject);
        int w;
        for (int i = 0; i < 4; i++) plan[i] = 8'hFF;
        plan[k] = fin;
        try_n = 0; starts = 0;
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check(busy === 1'b1 && ofs_sel === 3'b000, "R2", {busy, ofs_sel}, 4'b1000);
        @(negedge clk);
        check(adc_start === 1'b1, "R2", adc_start, 1);
        if (inject) begin
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        w = 0;
        while (result_valid !== 1'b1 && w < 300) begin
            @(negedge clk);
            w++;
        end
        check(result === {2'(k), fin}, "R3/R5", result, {2'(k), fin});
        check(busy === 1'b0, "R8", busy, 0);
        check(starts == k + 1, "R10", starts, k + 1);
        for (int i = 0; i <= k; i++)
            check(sel_seen[i] === exp_code(i), "R4", sel_seen[i], exp_code(i));
        if (k == 3) check(ofs_sel === 3'b000, "R6", ofs_sel, 0);
        @(negedge clk);
        check(result_valid === 1'b0, "R8", result_valid, 0);
        repeat (4) @(negedge clk);
        check(result === {2'(k), fin}, "R8", result, {2'(k), fin});
        if (k < 3) check(ofs_sel === exp_code(k), "R7", ofs_sel, exp_code(k));
        if (inject) check(busy === 1'b0 && starts == k + 1, "R9", starts, k + 1);
    endtask

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] f;
        int k;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 0 && result_valid === 0 && adc_start === 0 && ofs_sel === 0 && result === 0,
              "R1", {busy, result_valid, adc_start, ofs_sel, result}, 0);
        // directed corners
        lat = 2; run(0, 8'hFE, 0);
        lat = 1; run(0, 8'h00, 0);
        lat = 3; run(3, 8'hFF, 0);
        lat = 2; run(2, 8'h80, 0);
        lat = 4; run(1, 8'h11, 1);
        lat = 3; run(3, 8'h5A, 1);
        for (int n = 0; n < 40; n++) begin
            k = int'($urandom % 4);
            f = 8'($urandom);
            if (k < 3 && f == 8'hFF) f = 8'hFE;
            lat = 1 + int'($urandom % 5);
            run(k, f, ($urandom % 3) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule